// File: doc/BRIEF.md
# Character-ROM Instruction Fetch Sequencer

This block steps a 4-bit program counter through a 16-byte read-only character memory. Each memory byte is treated as an instruction. A printable byte is "executed" by handing it to a character display port. A zero byte is the one special instruction: it sends the counter back to zero and tells the display to wipe itself. The memory image is fixed when the block is elaborated, through a parameter.

A slow pacing clock is modelled as the `tick` clock enable. The counter moves only when `tick` and `cnt_en` are both high. A synchronous clear and a four-line parallel load let an operator restart the program or jump into it.

Each step first advances the counter and then reads the byte at the new address. For that reason, address 0 is read only when the count wraps from 15.

Top module: `charrom_seq`

## Requirements
- R1: While `rst_n` is low, `pc`, `char_out`, `char_valid` and `display_clear` are all zero. This takes effect at once, without waiting for a clock.
- R2: A step happens on a rising `clk` edge where `tick` and `cnt_en` are both high and `clr` and `load` are both low. On that edge, `pc` becomes its old value plus one, wrapping from 15 to 0, unless R7 applies. `char_out` takes the ROM byte at the new address.
- R3: If `tick` or `cnt_en` is low, and neither `clr` nor `load` is high, `pc` and `char_out` keep their values and both strobes stay low.
- R4: On an edge where `clr` is high, `pc` becomes 0 and both strobes stay low, whatever `load`, `tick` and `cnt_en` are doing. `char_out` is unchanged.
- R5: On an edge where `load` is high and `clr` is low, `pc` takes `load_val`, even if a step was requested. No fetch happens: both strobes stay low and `char_out` is unchanged.
- R6: A step that fetches a non-zero byte raises `char_valid` for exactly the one cycle after that edge, with the byte on `char_out`. `display_clear` stays low in that cycle.
- R7: A step that fetches byte 0x00 raises `display_clear` for exactly one cycle. In that cycle `pc` is 0, `char_out` is 0x00 and `char_valid` is low.
- R8: The byte at address i is `ROM_IMAGE[8*i+7:8*i]`. The default image holds "CPU", then 0x0D, then "RUN", then two 0x20 bytes at addresses 7 and 8, then 0x00 at addresses 9 through 15.
- R9: The two strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-tick clock enable for stepping |
| cnt_en | input | 1 | Count enable; stepping needs this high |
| clr | input | 1 | Synchronous clear of the counter |
| load | input | 1 | Parallel-load strobe |
| load_val | input | 4 | Value loaded into the counter |
| pc | output | 4 | Current program counter |
| char_out | output | 8 | Last fetched byte |
| char_valid | output | 1 | One-cycle strobe: print `char_out` |
| display_clear | output | 1 | One-cycle strobe: clear the display |

## Verification
All outputs except the reset values come from a single register stage. The counter, the character and the strobes for a stimulus applied before an edge are therefore due one edge later. The reset values are due immediately, with no edge needed.

The driver applies each cycle's inputs at the falling edge and queues the expected outputs for that cycle. The monitor takes one item from the queue at every rising edge and compares it shortly after that edge, so every comparison lands exactly one register delay after its stimulus. The reset value is checked a delta after `rst_n` falls, with no clock edge in between.

// File: rtl/charrom_seq.sv
module charrom_seq #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] ROM_IMAGE =
    {56'h0, 16'h2020, "NUR", 8'h0D, "UPC"}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cnt_en,
  input  logic              clr,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc,
  output logic [DATA_W-1:0] char_out,
  output logic              char_valid,
  output logic              display_clear
);

  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] fetched;
  logic              advance;

  assign advance   = tick && cnt_en;
  assign next_addr = pc + 1'b1;
  assign fetched   = ROM_IMAGE[int'(next_addr)*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc            <= '0;
      char_out      <= '0;
      char_valid    <= 1'b0;
      display_clear <= 1'b0;
    end else begin
      char_valid    <= 1'b0;
      display_clear <= 1'b0;
      if (clr) begin
        pc <= '0;
      end else if (load) begin
        pc <= load_val;
      end else if (advance) begin
        char_out <= fetched;
        if (fetched == '0) begin
          pc            <= '0;
          display_clear <= 1'b1;
        end else begin
          pc         <= next_addr;
          char_valid <= 1'b1;
        end
      end
    end
  end

  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pc == '0) && !char_valid && !display_clear);

  // R5
  load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load) |=> (pc == $past(load_val)) && !char_valid && !display_clear);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !(tick && cnt_en)) |=> $stable(pc) && $stable(char_out)
      && !char_valid && !display_clear);

  // R7
  null_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    display_clear |-> (pc == '0) && (char_out == '0));

  // R6
  printable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> (char_out != '0));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({char_valid, display_clear}) <= 1);

endmodule

// File: tb/charrom_seq_tb.sv
module charrom_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] IMG = {56'h0, 16'h2020, "NUR", 8'h0D, "UPC"};

  typedef struct {
    logic [3:0] pc;
    logic [7:0] ch;
    logic       v;
    logic       c;
    string      req;
  } exp_t;

  logic clk = 0, rst_n = 0, tick = 0, cnt_en = 0, clr = 0, load = 0;
  logic [3:0] load_val = '0;
  logic [3:0] pc;
  logic [7:0] char_out;
  logic char_valid, display_clear;

  int errors = 0, checks = 0;
  exp_t q[$];
  logic [3:0] m_pc = '0;
  logic [7:0] m_ch = '0;

  charrom_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_en(cnt_en), .clr(clr),
    .load(load), .load_val(load_val), .pc(pc), .char_out(char_out),
    .char_valid(char_valid), .display_clear(display_clear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [3:0] a);
    return IMG[a*8 +: 8];
  endfunction

  task automatic cyc(input logic tk, input logic en, input logic c,
                     input logic l, input logic [3:0] v, input string req);
    exp_t e;
    logic [3:0] na;
    logic [7:0] b;
    @(negedge clk);
    tick = tk; cnt_en = en; clr = c; load = l; load_val = v;
    e.v = 0; e.c = 0; e.req = req;
    if (c) m_pc = 0;
    else if (l) m_pc = v;
    else if (tk && en) begin
      na = m_pc + 4'd1;
      b = rom_byte(na);
      m_ch = b;
      if (b == 8'h00) begin m_pc = 0; e.c = 1; end
      else begin m_pc = na; e.v = 1; end
    end
    e.pc = m_pc; e.ch = m_ch;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (pc !== e.pc || char_out !== e.ch || char_valid !== e.v || display_clear !== e.c) begin
        errors++;
        $display("FAIL %s: got pc=%h ch=%h v=%b c=%b, expected pc=%h ch=%h v=%b c=%b",
                 e.req, pc, char_out, char_valid, display_clear, e.pc, e.ch, e.v, e.c);
      end
    end
  end

  task automatic reset_check(input string req);
    checks++;
    if (pc !== 0 || char_out !== 0 || char_valid !== 0 || display_clear !== 0) begin
      errors++;
      $display("FAIL %s: got pc=%h ch=%h v=%b c=%b, expected all zero",
               req, pc, char_out, char_valid, display_clear);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1 reset_check("R1");
    #(CLK_PERIOD*2);
    @(negedge clk) rst_n = 1;
    // R2 R6 R7 R8: walk the image through the null and past it
    for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0, 0, "R2/R6/R7/R8");
    // R3: hold with tick low, then with cnt_en low
    cyc(0, 1, 0, 0, 0, "R3");
    cyc(1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 0, "R3");
    // R5: load wins over step, then wrap 15->0 fetches 'C'
    cyc(1, 1, 0, 1, 4'hF, "R5");
    cyc(1, 1, 0, 0, 0, "R2 wrap");
    // R7: load 8, step hits null at 9
    cyc(0, 0, 0, 1, 4'h8, "R5");
    cyc(1, 1, 0, 0, 0, "R7");
    cyc(1, 1, 0, 0, 0, "R6");
    // R4: clear beats load and step
    cyc(1, 1, 0, 1, 4'h5, "R5");
    cyc(1, 1, 1, 1, 4'hA, "R4");
    cyc(1, 1, 0, 0, 0, "R6");
    cyc(0, 0, 1, 0, 0, "R4");
    // R9 across a longer run
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, 0, "R3");
    @(posedge clk); #2;
    // R1: asynchronous reset mid-run
    @(negedge clk) rst_n = 0;
    #1 reset_check("R1");
    m_pc = 0; m_ch = 0;
    @(negedge clk) rst_n = 1;
    cyc(1, 1, 0, 0, 0, "R1/R2");
    cyc(0, 0, 0, 0, 0, "R3");
    @(posedge clk); #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule